// File: doc/BRIEF.md
# RFI Transient Clipper

This block sits on the real time-domain sample stream ahead of a channelising filter bank and removes short, strong impulses. It keeps two exponential averages, one of the sample value (the running mean) and one of the squared deviation from that mean (the running variance). Both decay with a time constant of 2^k samples, where the shift count k comes from a configuration input. Each sample's squared deviation is compared with the running variance multiplied by an unsigned 16-bit threshold. A sample that exceeds that limit is judged a transient and is replaced by the running mean. All other samples pass through unchanged.

Every accepted sample appears at the output exactly one clock later, whether or not it was replaced. A flag marks the samples that were replaced, and a saturating counter tallies them. A replaced sample does not update either average, so a burst of impulses cannot raise the limit that catches it. Right after reset the averages hold no history, so clipping is held off until 2^k samples have been accepted. A threshold of zero turns clipping off entirely.

Top module: `rfi_clipper`

## Requirements
- R1: Each cycle with `inValid` high produces `outValid` high on the following cycle, and `outValid` is low in the cycle after an idle input cycle. Idle cycles change neither average, the warm-up count nor `clipCount`.
- R2: The running mean M is a signed 9-bit integer and is 0 after reset. For each accepted sample x that is not replaced, M becomes M + ((x − M) >>> k). Here >>> is an arithmetic right shift (floor division by 2^k) and k = `cfgShift` (0 to 7).
- R3: The running variance V is an unsigned integer and is 0 after reset. For each accepted sample that is not replaced, V becomes V + ((d² − V) >>> k), where d = x − M and M is the mean before the update. A replaced sample leaves both M and V unchanged.
- R4: A sample is replaced when all of the following hold: `cfgThresh` T is not 0, warm-up is over, and d² > V × T, with the comparison at full precision.
- R5: The output value of a replaced sample is M as it stood before that sample. The output value of any other sample is the input sample itself.
- R6: With T = 0 no sample is replaced, whatever its size.
- R7: Samples are numbered 0, 1, 2, … in order of acceptance since reset. Sample i can be replaced only if i ≥ 2^k, using the k in force when it arrives. The warm-up count saturates at 128, so that from then on every k is past warm-up.
- R8: `outClipped` is high, together with `outValid`, exactly for output samples that were replaced, and is low in every other cycle.
- R9: `clipCount` is 0 after reset and rises by one in the same cycle as each asserted `outClipped`. It holds its value otherwise, and it saturates at 65535.
- R10: While reset is applied and right after it, `outValid`, `outClipped`, `outSample` and `clipCount` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 9 | Signed input sample |
| cfgShift | input | 3 | Averaging shift count k (time constant 2^k samples) |
| cfgThresh | input | 16 | Unsigned threshold multiplier; 0 disables clipping |
| outValid | output | 1 | Output sample strobe, one cycle after input |
| outSample | output | 9 | Signed output sample (input value or running mean) |
| outClipped | output | 1 | High for output samples that were replaced |
| clipCount | output | 16 | Saturating count of replaced samples |

## Verification
Two events can fall in the same cycle: the end of warm-up and the detection of a transient. The bench provokes this with k = 2, a quiet start, an impulse on sample 3 and a second impulse on sample 4. Sample 3 must pass unchanged because it is the last warm-up sample. Sample 4 must come out as the mean of 25 produced by sample 3, with the flag and the counter rising in that same cycle. A second pairing is saturation of the counter and a new replacement. A long run of impulses drives the counter to 65535, and that final cycle must still raise the flag while the count stays put.

// File: rtl/clipper_pkg.sv
package clipper_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic take;         // a sample is accepted this cycle
    logic clipAllowed;  // warm-up done and threshold non-zero
  } ctrlStrobe_t;
endpackage

// File: rtl/clipper_ctrl.sv
module clipper_ctrl
  import clipper_pkg::*;
#(
  parameter int SHIFT_W = 3,
  parameter int THR_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [THR_W-1:0]   cfgThresh,
  input  logic               clipNow,
  output ctrlStrobe_t        strobe,
  output logic [CNT_W-1:0]   clipCount
);
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
  localparam int WARM_W    = MAX_SHIFT + 1;
  localparam logic [WARM_W-1:0] WARM_FULL = WARM_W'(1) << MAX_SHIFT;

  logic [WARM_W-1:0] warmCnt;
  logic [WARM_W-1:0] warmTarget;
  logic              warmDone;

  always_comb begin
    warmTarget         = WARM_W'(1) << cfgShift;
    warmDone           = warmCnt >= warmTarget;
    strobe.take        = inValid;
    strobe.clipAllowed = warmDone && (cfgThresh != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt   <= '0;
      clipCount <= '0;
    end else begin
      if (strobe.take && warmCnt != WARM_FULL)
        warmCnt <= warmCnt + WARM_W'(1);
      if (strobe.take && clipNow && clipCount != '1)
        clipCount <= clipCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/clipper_datapath.sv
module clipper_datapath
  import clipper_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int SHIFT_W = 3,
  parameter int THR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic [SHIFT_W-1:0]       cfgShift,
  input  logic [THR_W-1:0]         cfgThresh,
  output logic                     clipNow,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample,
  output logic                     outClipped
);
  localparam int VAR_W  = 2 * DATA_W;
  localparam int PROD_W = VAR_W + THR_W;

  logic signed [DATA_W-1:0] meanQ;
  logic [VAR_W-1:0]         varQ;

  logic signed [DATA_W:0]   dev;
  logic [DATA_W-1:0]        absDev;
  logic [VAR_W-1:0]         sq;
  logic [PROD_W-1:0]        limit;
  logic                     overLimit;
  logic signed [DATA_W:0]   meanStep;
  logic signed [DATA_W-1:0] meanNext;
  logic signed [VAR_W:0]    varDiff;
  logic signed [VAR_W:0]    varStep;
  logic [VAR_W-1:0]         varNext;

  always_comb begin
    dev       = $signed({inSample[DATA_W-1], inSample}) - $signed({meanQ[DATA_W-1], meanQ});
    absDev    = DATA_W'(dev[DATA_W] ? -dev : dev);
    sq        = VAR_W'(absDev) * VAR_W'(absDev);
    limit     = PROD_W'(varQ) * PROD_W'(cfgThresh);
    overLimit = PROD_W'(sq) > limit;
    clipNow   = strobe.clipAllowed && overLimit;
    meanStep  = dev >>> cfgShift;
    meanNext  = DATA_W'($signed({meanQ[DATA_W-1], meanQ}) + meanStep);
    varDiff   = $signed({1'b0, sq}) - $signed({1'b0, varQ});
    varStep   = varDiff >>> cfgShift;
    varNext   = VAR_W'($signed({1'b0, varQ}) + varStep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meanQ      <= '0;
      varQ       <= '0;
      outValid   <= 1'b0;
      outSample  <= '0;
      outClipped <= 1'b0;
    end else begin
      outValid   <= strobe.take;
      outClipped <= strobe.take && clipNow;
      if (strobe.take) begin
        outSample <= clipNow ? meanQ : inSample;
        if (!clipNow) begin
          meanQ <= meanNext;
          varQ  <= varNext;
        end
      end
    end
  end
endmodule

// File: rtl/rfi_clipper.sv
module rfi_clipper
  import clipper_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int SHIFT_W = 3,
  parameter int THR_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic [SHIFT_W-1:0]       cfgShift,
  input  logic [THR_W-1:0]         cfgThresh,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample,
  output logic                     outClipped,
  output logic [CNT_W-1:0]         clipCount
);
  ctrlStrobe_t strobe;
  logic        clipNow;

  clipper_ctrl #(.SHIFT_W(SHIFT_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgShift(cfgShift),
    .cfgThresh(cfgThresh), .clipNow(clipNow), .strobe(strobe), .clipCount(clipCount)
  );

  clipper_datapath #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSample(inSample),
    .cfgShift(cfgShift), .cfgThresh(cfgThresh), .clipNow(clipNow),
    .outValid(outValid), .outSample(outSample), .outClipped(outClipped)
  );
endmodule

// File: rtl/rfi_clipper_chk.sv
module rfi_clipper_chk #(
  parameter int DATA_W = 9,
  parameter int THR_W  = 16,
  parameter int CNT_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inSample,
  input logic [THR_W-1:0]         cfgThresh,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outSample,
  input logic                     outClipped,
  input logic [CNT_W-1:0]         clipCount
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(clipCount)));

  // R6
  thresh_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgThresh == '0) |=> (!outClipped && outSample == $past(inSample)));

  // R8
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outClipped |-> outValid);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outClipped && $past(clipCount) != '1) |-> clipCount == $past(clipCount) + CNT_W'(1));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outClipped |-> $stable(clipCount));
endmodule

bind rfi_clipper rfi_clipper_chk #(.DATA_W(DATA_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
  .cfgThresh(cfgThresh), .outValid(outValid), .outSample(outSample),
  .outClipped(outClipped), .clipCount(clipCount)
);

// File: tb/rfi_clipper_bench.sv
`timescale 1ns/1ps
module rfi_clipper_bench;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic signed [8:0] inSample = '0;
  logic [2:0]        cfgShift = 3'd0;
  logic [15:0]       cfgThresh = 16'd0;
  logic              outValid;
  logic signed [8:0] outSample;
  logic              outClipped;
  logic [15:0]       clipCount;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int mMean, mWarm, mCnt;
  longint mVar;

  always #5 clk = ~clk;

  rfi_clipper u_rfi_clipper (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .cfgShift(cfgShift), .cfgThresh(cfgThresh), .outValid(outValid),
    .outSample(outSample), .outClipped(outClipped), .clipCount(clipCount)
  );

  task automatic checkEq(input string tag, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    // R10: outputs while reset is held
    checkEq("R10 outValid in reset", outValid, 0);
    checkEq("R10 outClipped in reset", outClipped, 0);
    checkEq("R10 outSample in reset", outSample, 0);
    checkEq("R10 clipCount in reset", clipCount, 0);
    rstN = 1'b1;
    mMean = 0; mVar = 0; mWarm = 0; mCnt = 0;
    @(negedge clk);
    checkEq("R10 outValid after reset", outValid, 0);
    checkEq("R10 clipCount after reset", clipCount, 0);
  endtask

  task automatic setCfg(input int k, input int t);
    @(negedge clk);
    inValid = 1'b0;
    cfgShift = 3'(k);
    cfgThresh = 16'(t);
  endtask

  // Sends one sample, updates the reference model from R2..R9, checks the result
  task automatic sendSample(input int x, input bit doCheck, output bit wasClipped);
    int k, d, expOut;
    longint d2, lim;
    bit clip;
    k = int'(cfgShift);
    @(negedge clk);
    inValid = 1'b1;
    inSample = 9'(x);
    d = x - mMean;
    d2 = longint'(d) * longint'(d);
    lim = mVar * longint'(cfgThresh);
    clip = (cfgThresh != 0) && (mWarm >= (1 << k)) && (d2 > lim);
    expOut = clip ? mMean : x;
    if (!clip) begin
      mMean = mMean + (d >>> k);
      mVar = mVar + ((d2 - mVar) >>> k);
    end
    if (mWarm < 128) mWarm++;
    if (clip && mCnt < 65535) mCnt++;
    wasClipped = clip;
    @(posedge clk);
    #1;
    if (doCheck) begin
      checkEq("R1 outValid after sample", outValid, 1);
      checkEq("R5 outSample", outSample, expOut);
      checkEq("R8 outClipped", outClipped, clip);
      checkEq("R9 clipCount", clipCount, mCnt);
    end
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0;
    inSample = 9'sd77;
    @(posedge clk);
    #1;
    checkEq("R1 outValid idle", outValid, 0);
    checkEq("R8 outClipped idle", outClipped, 0);
    checkEq("R1 clipCount idle", clipCount, mCnt);
  endtask

  task automatic testReset();
    applyReset();
  endtask

  task automatic testWarmup();
    bit c;
    applyReset();
    setCfg(2, 4);
    sendSample(0, 1, c);
    sendSample(0, 1, c);
    sendSample(0, 1, c);
    sendSample(100, 1, c);
    // R7: sample 3 is the last warm-up sample and passes
    checkEq("R7 last warm-up sample passes", outSample, 100);
    checkEq("R7 last warm-up flag", outClipped, 0);
    sendSample(-200, 1, c);
    // R4 R5: first sample after warm-up replaced by mean 25
    checkEq("R4 spike after warm-up flagged", outClipped, 1);
    checkEq("R5 replaced by mean", outSample, 25);
    checkEq("R9 count after first clip", clipCount, 1);
  endtask

  task automatic testStream();
    bit c;
    int clips = 0;
    setCfg(3, 9);
    for (int i = 0; i < 40; i++) begin
      sendSample((i % 2 == 0) ? 20 : -20, 1, c);
    end
    for (int i = 0; i < 30; i++) begin
      sendSample((i % 10 == 5) ? 250 : (i * 3 - 45), 1, c);
      if (c) clips++;
    end
    for (int i = 0; i < 30; i++) begin
      sendSample((i % 7 == 3) ? -256 : ((i % 3) - 1) * 15, 1, c);
      if (c) clips++;
    end
    // R4: the stream must have produced replacements
    testsRun++;
    if (clips == 0) begin
      testsFailed++;
      $display("FAIL R4 stream clips actual=%0d expected=>0", clips);
    end
  endtask

  task automatic testBackToBack();
    bit c;
    setCfg(3, 9);
    for (int i = 0; i < 4; i++) begin
      sendSample(255, 1, c);
      // R3: replaced spikes do not inflate variance, so each is replaced
      checkEq("R3 repeated spike still clipped", outClipped, 1);
    end
  endtask

  task automatic testThreshOff();
    bit c;
    setCfg(3, 0);
    sendSample(255, 1, c);
    checkEq("R6 spike passes with T=0", outSample, 255);
    sendSample(-256, 1, c);
    checkEq("R6 negative spike passes with T=0", outSample, -256);
    checkEq("R6 flag low with T=0", outClipped, 0);
  endtask

  task automatic testIdle();
    bit c;
    int meanBefore;
    setCfg(2, 9);
    for (int i = 0; i < 8; i++) sendSample(i - 4, 1, c);
    meanBefore = mMean;
    for (int i = 0; i < 3; i++) idleCycle();
    sendSample(250, 1, c);
    // R1: idle cycles left the mean untouched
    checkEq("R1 mean held over idle gap", outSample, meanBefore);
  endtask

  task automatic testShiftZero();
    bit c;
    setCfg(0, 2);
    for (int i = 0; i < 12; i++) sendSample((i % 4) * 40 - 60, 1, c);
    sendSample(255, 1, c);
    sendSample(-256, 1, c);
  endtask

  task automatic testSaturate();
    bit c;
    applyReset();
    setCfg(0, 1);
    sendSample(0, 1, c);
    for (int i = 0; i < 65534; i++) sendSample(255, 0, c);
    sendSample(255, 1, c);
    checkEq("R9 count reaches max", clipCount, 65535);
    sendSample(255, 1, c);
    checkEq("R9 count saturates", clipCount, 65535);
    checkEq("R8 flag at saturation", outClipped, 1);
  endtask

  initial begin
    testReset();
    testWarmup();
    testStream();
    testBackToBack();
    testThreshOff();
    testIdle();
    testShiftZero();
    testSaturate();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule